// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit collects the four interrupt causes of a classic single-byte-buffer UART and makes them visible to a processor. The four causes are a receive line fault, a received byte waiting, an empty transmit holding register, and a change on a modem control input. The logic that finds these events lives elsewhere. Each one reaches this unit as a single-cycle set pulse. The unit latches each cause in a sticky flag. It masks the flags with a four-bit enable register that software writes. It then raises one interrupt request line whenever any enabled cause is waiting.

The processor sees the unit through a small register port. It can read and write the enable register. It can read an identification register that reports whether an interrupt is waiting and, if so, which enabled cause has the highest rank.

Some register accesses clear a cause as a side effect:
- Reading the received-data location clears the receive cause.
- Reading the line status location clears the line fault cause.
- Reading the modem status location clears the modem cause.
- Writing the transmit data location clears the transmit cause.
- Reading the identification register clears the transmit cause, but only when that register is currently reporting the transmit cause.

Top module: `uirq_ident`

## Requirements
- R1: The enable register keeps only write-data bits 3:0 and reads back with bits 7:4 at zero. Bit 0 enables received data, bit 1 enables transmit holding empty, bit 2 enables line fault and bit 3 enables modem change.
- R2: In the identification register, bit 0 is 0 while an enabled cause is waiting and 1 otherwise, and bits 7:4 read as zero. With nothing waiting, the register reads 0x01.
- R3: Identification bits 3:1 hold the code of the highest-ranked enabled waiting cause. From highest rank to lowest, the codes are line fault 011, received data 010, transmit empty 001 and modem change 000.
- R4: A cause whose enable bit is clear still latches. It is left out of the request and the identification code until its enable bit is set.
- R5: `irq` is high exactly while at least one enabled cause is waiting.
- R6: Reading the identification register while it reports code 001 clears the transmit cause. A read that reports any other code leaves the transmit cause waiting.
- R7: Writing the enable register with bit 1 set while `thr_empty` is high makes the transmit cause wait at once. The same write with `thr_empty` low does not.
- R8: A read of the received-data location (address 0) clears the receive cause.
- R9: A read of the line status location (address 5) clears the line fault cause.
- R10: A read of the modem status location (address 6) clears the modem cause.
- R11: A write to the transmit data location (address 0) clears the transmit cause.
- R12: A set pulse that arrives in the same cycle as a clearing access leaves its cause waiting.
- R13: After reset, the enable register reads 0, no cause is waiting and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register select (0 data, 1 enable, 2 identification, 5 line status, 6 modem status) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; side effects apply at the clock edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the enable and identification registers, zero otherwise |
| ls_err_set | input | 1 | Line fault event pulse |
| rx_ready_set | input | 1 | Received byte event pulse |
| thr_empty_set | input | 1 | Transmit holding register became empty |
| ms_change_set | input | 1 | Modem input change pulse |
| thr_empty | input | 1 | Current transmit holding empty level |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches several properties on every cycle:
- the zero upper bits of both readable registers;
- agreement between `irq` and the pending bit of the identification register;
- that an enabled receive event raises the request on the next cycle;
- that line fault and transmit causes are gone after their clearing accesses.

Some behaviour only the bench's scenarios show. It sweeps all sixteen waiting patterns against all sixteen enable values, and this sweep is what proves the ranking and masking. The bench also covers whether a masked cause survives until it is enabled, the conditional effect of an enable write on the transmit cause, and the rule that a set beats a clear in the same cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   localparam int N_SRC  = 4;
   localparam int CODE_W = $clog2(N_SRC);
   // source slots; slot index equals the identification code, higher wins
   localparam int SRC_MS = 0;
   localparam int SRC_TX = 1;
   localparam int SRC_RX = 2;
   localparam int SRC_LS = 3;
   // register map
   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_IEN  = 3'd1;
   localparam logic [2:0] A_IID  = 3'd2;
   localparam logic [2:0] A_LSTA = 3'd5;
   localparam logic [2:0] A_MSTA = 3'd6;
endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/uirq_pending_bank.sv
module uirq_pending_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pend[i] <= 1'b0;
            else if (set[i]) pend[i] <= 1'b1;   // set beats clear
            else if (clr[i]) pend[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc #(
   parameter int N  = 4,
   localparam int CW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [CW-1:0] code
);
   always_comb begin
      code = '0;
      for (int i = 0; i < N; i++)
         if (req[i]) code = CW'(i);   // highest index wins
   end
   assign any = |req;
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
   import uirq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ls_err_set,
   input  logic              rx_ready_set,
   input  logic              thr_empty_set,
   input  logic              ms_change_set,
   input  logic              thr_empty,
   output logic              irq
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("uirq_ident: DATA_W must be at least 8");
      end
   endgenerate

   logic [N_SRC-1:0]  ier;
   logic [N_SRC-1:0]  pend;
   logic [N_SRC-1:0]  en_src;
   logic [N_SRC-1:0]  set_v;
   logic [N_SRC-1:0]  clr_v;
   logic              any_act;
   logic [CODE_W-1:0] code;
   logic              ier_wr;
   logic              unused_hi;

   assign ier_wr    = wr_en && (addr == A_IEN);
   assign unused_hi = ^wr_data[DATA_W-1:N_SRC];

   uirq_enable_reg #(.W(N_SRC)) u_ier (
      .clk(clk), .rst_n(rst_n), .we(ier_wr),
      .d(wr_data[N_SRC-1:0]), .q(ier)
   );

   // enable bits are laid out by the register map; slots by rank
   always_comb begin
      en_src         = '0;
      en_src[SRC_RX] = ier[0];
      en_src[SRC_TX] = ier[1];
      en_src[SRC_LS] = ier[2];
      en_src[SRC_MS] = ier[3];
   end

   always_comb begin
      set_v         = '0;
      set_v[SRC_LS] = ls_err_set;
      set_v[SRC_RX] = rx_ready_set;
      set_v[SRC_TX] = thr_empty_set || (ier_wr && wr_data[1] && thr_empty);
      set_v[SRC_MS] = ms_change_set;
   end

   always_comb begin
      clr_v         = '0;
      clr_v[SRC_RX] = rd_en && (addr == A_DATA);
      clr_v[SRC_LS] = rd_en && (addr == A_LSTA);
      clr_v[SRC_MS] = rd_en && (addr == A_MSTA);
      clr_v[SRC_TX] = (wr_en && (addr == A_DATA)) ||
                      (rd_en && (addr == A_IID) && any_act &&
                       (code == CODE_W'(SRC_TX)));
   end

   uirq_pending_bank #(.N(N_SRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .pend(pend)
   );

   uirq_prio_enc #(.N(N_SRC)) u_enc (
      .req(pend & en_src), .any(any_act), .code(code)
   );

   assign irq = any_act;

   always_comb begin
      rd_data = '0;
      if (addr == A_IEN) begin
         rd_data[N_SRC-1:0] = ier;
      end else if (addr == A_IID) begin
         rd_data[0]        = ~any_act;
         rd_data[CODE_W:1] = code;
      end
   end
endmodule

// File: rtl/uirq_ident_chk.sv
module uirq_ident_chk
   import uirq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              ls_err_set,
   input logic              rx_ready_set,
   input logic              thr_empty_set,
   input logic              thr_empty,
   input logic              irq,
   input logic [N_SRC-1:0]  ier,
   input logic [N_SRC-1:0]  pend
);
   AST_IEN_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_IEN) |-> (rd_data[7:4] == 4'h0)); // R1

   AST_IID_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_IID) |-> (rd_data[7:3] == 5'h0)); // R2

   AST_IRQ_MATCHES_IID: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_IID) |-> (irq == !rd_data[0])); // R5

   AST_RX_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready_set && ier[0] && !(wr_en && addr == A_IEN)) |=> irq); // R5

   AST_LS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_LSTA && !ls_err_set) |=> !pend[SRC_LS]); // R9

   AST_TX_ID_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_IID && rd_data[3:0] == 4'b0010 && !thr_empty_set &&
       !(wr_en && addr == A_IEN && wr_data[1] && thr_empty))
      |=> !pend[SRC_TX]); // R6
endmodule

bind uirq_ident uirq_ident_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_uirq_ident.sv
`timescale 1ns/1ps
module sim_uirq_ident;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       ls_err_set = 0, rx_ready_set = 0, thr_empty_set = 0, ms_change_set = 0;
   logic       thr_empty = 0;
   logic       irq;
   int         n_tests = 0, n_fail = 0;
   bit         done = 0;

   always #4 clk = ~clk;

   uirq_ident u0 (.*);

   task automatic cyc();
      @(posedge clk); #2;
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0; wr_en = 0; rd_en = 0;
      {ls_err_set, rx_ready_set, thr_empty_set, ms_change_set} = '0;
      cyc(); rst_n = 1; cyc();
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1; cyc(); wr_en = 0;
   endtask

   // read with check of the combinational value before the edge
   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
      addr = a; rd_en = 1; #1; chk(tag, rd_data, exp); cyc(); rd_en = 0;
   endtask

   task automatic rd_nc(input logic [2:0] a);
      addr = a; rd_en = 1; cyc(); rd_en = 0;
   endtask

   // bit order {ls, rx, tx, ms}
   task automatic pulse(input logic [3:0] v);
      {ls_err_set, rx_ready_set, thr_empty_set, ms_change_set} = v; cyc();
      {ls_err_set, rx_ready_set, thr_empty_set, ms_change_set} = '0;
   endtask

   function automatic logic [7:0] exp_iid(input logic [3:0] p, input logic [3:0] ien);
      logic [3:0] en_s, act;
      en_s = {ien[2], ien[0], ien[1], ien[3]};
      act  = p & en_s;
      if (act == 0) return 8'h01;
      for (int i = 3; i >= 0; i--) if (act[i]) return 8'(i << 1);
      return 8'h01;
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R13 reset state
      chk("R13 irq", {7'd0, irq}, 8'h00);
      rd(3'd1, 8'h00, "R13 ien");
      rd(3'd2, 8'h01, "R13 iid");
      // R1 upper bits dropped
      wr(3'd1, 8'hFF);
      rd(3'd1, 8'h0F, "R1 ien");
      wr(3'd1, 8'hA5);
      rd(3'd1, 8'h05, "R1 ien2");

      // R2 R3 R4 R5 exhaustive sweep of pending x enable
      for (int p = 0; p < 16; p++) begin
         for (int e = 0; e < 16; e++) begin
            do_reset();
            wr(3'd1, 8'(e));
            pulse(4'(p));
            #1;
            chk("R5 irq", {7'd0, irq}, {7'd0, exp_iid(4'(p), 4'(e)) != 8'h01});
            rd(3'd2, exp_iid(4'(p), 4'(e)), "R3 iid");
         end
      end

      // R4 masked cause survives, shows after enable
      do_reset();
      pulse(4'b0100);
      rd(3'd2, 8'h01, "R4 masked");
      wr(3'd1, 8'h01);
      rd(3'd2, 8'h04, "R4 enabled");

      // R6 ID read clears tx only when shown
      do_reset();
      wr(3'd1, 8'h03);
      pulse(4'b0110);
      rd(3'd2, 8'h04, "R6 rx shown");
      rd_nc(3'd0);                        // R8 clear rx
      rd(3'd2, 8'h02, "R6 tx kept");
      rd(3'd2, 8'h01, "R6 tx cleared");

      // R7 enable write with holding empty
      do_reset();
      thr_empty = 0; wr(3'd1, 8'h02);
      rd(3'd2, 8'h01, "R7 not empty");
      thr_empty = 1; wr(3'd1, 8'h02); thr_empty = 0;
      rd(3'd2, 8'h02, "R7 empty");

      // R8 data read clears rx
      do_reset(); wr(3'd1, 8'h01); pulse(4'b0100);
      rd(3'd2, 8'h04, "R8 before"); rd_nc(3'd0);
      rd(3'd2, 8'h01, "R8 after");

      // R9 line status read clears ls
      do_reset(); wr(3'd1, 8'h04); pulse(4'b1000);
      rd(3'd2, 8'h06, "R9 before"); rd_nc(3'd5);
      rd(3'd2, 8'h01, "R9 after");

      // R10 modem status read clears ms
      do_reset(); wr(3'd1, 8'h08); pulse(4'b0001);
      rd(3'd2, 8'h00, "R10 before"); rd_nc(3'd6);
      rd(3'd2, 8'h01, "R10 after");

      // R11 data write clears tx
      do_reset(); wr(3'd1, 8'h02); pulse(4'b0010);
      rd(3'd5, 8'h00, "R11 other");
      wr(3'd0, 8'h55);
      rd(3'd2, 8'h01, "R11 after");

      // R12 set beats simultaneous clear
      do_reset(); wr(3'd1, 8'h01);
      addr = 3'd0; rd_en = 1; rx_ready_set = 1; cyc(); rd_en = 0; rx_ready_set = 0;
      rd(3'd2, 8'h04, "R12 rx");
      wr(3'd1, 8'h04);
      addr = 3'd5; rd_en = 1; ls_err_set = 1; cyc(); rd_en = 0; ls_err_set = 0;
      rd(3'd2, 8'h06, "R12 ls");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule